// File: doc/BRIEF.md
# Banked Multi-Channel PWM Engine

This block drives 64 pulse-width-modulated channels from one shared 8-bit counter. The counter advances at a rate set by an 8-bit prescaler, and every channel compares that counter with its own 8-bit duty value. The host writes the duty values of channels 0 to 55 and the prescaler through a simple write port. Channels 56 to 63 form a reserved bank. Their duty values come live from an internal modulation source on the `mod_duty` input, and host writes to those channels have no effect.

The channels are grouped into eight banks of eight. A 3-bit bank index selects one bank for the primary output byte, and the secondary output byte shows the bank after it. When the page-select input is high, the secondary output shows a status word instead, which is the current counter value. A synchronous clear input returns all duty registers, the prescaler and the counting state to zero.

Top module: `pwm_bank_hub`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the counter, the divider, the prescaler and every host duty register are zero, so with `mod_duty` at zero both output bytes are 0.
- R2: A channel's output is 1 exactly while the counter value is strictly less than its duty value. A duty of 0 is always low, and at counter value 255 every channel is low.
- R3: With prescaler value N, the counter steps by one, wrapping from 255 to 0, at each edge where the internal divider count is at least N. That edge resets the divider to 0, and every other edge adds one to it, so a steady N gives one step every N+1 cycles. A prescaler write takes effect from the next edge.
- R4: `pri_out` bit i shows channel 8*`bank_sel`+i.
- R5: With `status_page` low, `sec_out` bit i shows channel 8*((`bank_sel`+1) mod 8)+i, so bank 7 wraps to bank 0.
- R6: With `status_page` high, `sec_out` equals the current counter value and `pri_out` is unchanged.
- R7: Channel 56+k takes its duty from `mod_duty[8k+7:8k]` with no register delay, and a host write to addresses 56 to 63 changes no output.
- R8: `clr` high at an edge zeroes all host duty registers, the prescaler, the counter and the divider, and it takes priority over a duty or prescaler write in the same cycle.
- R9: With `wr_en` high at an edge, channel `wr_addr` (0 to 55) takes duty `wr_data`, which is visible at the outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of duties, prescaler and counter |
| wr_en | input | 1 | Duty write strobe |
| wr_addr | input | 6 | Channel index of the duty write |
| wr_data | input | 8 | Duty value to write |
| psc_we | input | 1 | Prescaler write strobe |
| psc_data | input | 8 | Prescaler value to write |
| mod_duty | input | 64 | Live duty values of channels 56 to 63, eight bits each |
| bank_sel | input | 3 | Bank shown on the primary output |
| status_page | input | 1 | Replaces the secondary output with the status word |
| pri_out | output | 8 | PWM outputs of the selected bank |
| sec_out | output | 8 | PWM outputs of the next bank, or the status word |

## Verification
The assertions check on every cycle that the counter holds or steps by one as the divider and prescaler require, that clear and reset leave the counting state at zero, that every output is low at the top counter value, and that the status page mirrors the counter. Only the bench scenarios can show that a write lands on the intended channel, that the bank routing and the wrap from bank 7 to bank 0 are right, and that the reserved bank follows the modulation input while ignoring host writes. The reference model tracks all 64 duty values and the counter, so each of these is compared on every clock across changes of bank, prescaler and page.

// File: rtl/pwm_bank_hub.sv
module pwm_bank_hub #(
  parameter int DW = 8,
  parameter int NBANKS = 8,
  parameter int BW = 8,
  localparam int NCH = NBANKS * BW,
  localparam int AW = $clog2(NCH),
  localparam int SW = $clog2(NBANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             psc_we,
  input  logic [DW-1:0]    psc_data,
  input  logic [BW*DW-1:0] mod_duty,
  input  logic [SW-1:0]    bank_sel,
  input  logic             status_page,
  output logic [BW-1:0]    pri_out,
  output logic [BW-1:0]    sec_out
);

  localparam int MBASE = NCH - BW;

  logic [DW-1:0] psc_q, div_cnt, cnt;
  logic [DW-1:0] duty_all [NCH];
  logic [NCH-1:0] pwm;
  logic [SW-1:0] nxt_bank;
  logic tick, wipe;

  assign wipe = !rst_n || clr;
  assign tick = div_cnt >= psc_q;

  always_ff @(posedge clk) begin
    if (wipe) begin
      psc_q   <= '0;
      div_cnt <= '0;
      cnt     <= '0;
    end else begin
      if (psc_we) psc_q <= psc_data;
      if (tick) begin
        div_cnt <= '0;
        cnt     <= cnt + DW'(1);
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c < MBASE) begin : g_host
      logic [DW-1:0] duty_q;
      always_ff @(posedge clk) begin
        if (wipe) duty_q <= '0;
        else if (wr_en && wr_addr == AW'(c)) duty_q <= wr_data;
      end
      assign duty_all[c] = duty_q;
    end else begin : g_mod
      assign duty_all[c] = mod_duty[(c-MBASE)*DW +: DW];
    end
    assign pwm[c] = cnt < duty_all[c];
  end

  assign nxt_bank = bank_sel + SW'(1);
  assign pri_out  = pwm[int'(bank_sel)*BW +: BW];
  assign sec_out  = status_page ? BW'(cnt) : pwm[int'(nxt_bank)*BW +: BW];

endmodule

// File: rtl/pwm_bank_hub_chk.sv
module pwm_bank_hub_chk #(
  parameter int DW = 8,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          status_page,
  input logic [BW-1:0] pri_out,
  input logic [BW-1:0] sec_out,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] div_cnt,
  input logic [DW-1:0] psc_q
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cnt == '0 && div_cnt == '0 && psc_q == '0)); // R1

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && div_cnt == '0 && psc_q == '0)); // R8

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && div_cnt < psc_q) |=> $stable(cnt)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && div_cnt >= psc_q) |=> cnt == DW'($past(cnt) + DW'(1))); // R3

  AST_TOP_COUNT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1) |-> (pri_out == '0 && (status_page || sec_out == '0))); // R2

  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    status_page |-> sec_out == BW'(cnt)); // R6

endmodule

bind pwm_bank_hub pwm_bank_hub_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .status_page(status_page),
  .pri_out(pri_out), .sec_out(sec_out),
  .cnt(cnt), .div_cnt(div_cnt), .psc_q(psc_q)
);

// File: tb/tb_pwm_bank_hub.sv
module tb_pwm_bank_hub;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic psc_we = 1'b0;
  logic [7:0] psc_data = '0;
  logic [63:0] mod_duty = '0;
  logic [2:0] bank_sel = '0;
  logic status_page = 1'b0;
  logic [7:0] pri_out, sec_out;

  pwm_bank_hub dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .psc_we(psc_we), .psc_data(psc_data),
    .mod_duty(mod_duty), .bank_sel(bank_sel), .status_page(status_page),
    .pri_out(pri_out), .sec_out(sec_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_duty [56];
  int m_psc = 0, m_div = 0, m_cnt = 0;
  bit m_valid = 0;
  int vectors = 0, miscompares = 0;
  bit done = 0;
  string tag = "R1";

  function automatic int chan_duty(int c);
    if (c >= 56) return int'(mod_duty[(c-56)*8 +: 8]);
    return m_duty[c];
  endfunction

  function automatic logic [7:0] bank_bits(int b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (m_cnt < chan_duty(b*8+i));
    return r;
  endfunction

  task automatic check();
    logic [7:0] ep, es;
    if (!m_valid) return;
    ep = bank_bits(int'(bank_sel));
    es = status_page ? 8'(m_cnt) : bank_bits((int'(bank_sel) + 1) % 8);
    vectors++;
    if (pri_out !== ep || sec_out !== es) begin
      miscompares++;
      $display("FAIL %s pri_out=%h exp %h sec_out=%h exp %h (bank %0d page %0d)",
               tag, pri_out, ep, sec_out, es, bank_sel, status_page);
    end
  endtask

  task automatic model_edge();
    bit t;
    if (!rst_n || clr) begin
      foreach (m_duty[i]) m_duty[i] = 0;
      m_psc = 0; m_div = 0; m_cnt = 0;
    end else begin
      if (wr_en && int'(wr_addr) < 56) m_duty[int'(wr_addr)] = int'(wr_data);
      t = (m_div >= m_psc);
      if (psc_we) m_psc = int'(psc_data);
      if (t) begin m_div = 0; m_cnt = (m_cnt + 1) % 256; end
      else m_div = m_div + 1;
    end
    m_valid = 1;
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      #1; check();
      @(posedge clk); model_edge();
      @(negedge clk);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 6'(a); wr_data = 8'(d);
    cyc();
    wr_en = 0;
  endtask

  task automatic set_psc(int v);
    psc_we = 1; psc_data = 8'(v);
    cyc();
    psc_we = 0;
  endtask

  initial begin
    foreach (m_duty[i]) m_duty[i] = 0;
    @(negedge clk);
    tag = "R1";
    cyc(3);
    rst_n = 1;
    cyc(2);
    status_page = 1; cyc(2); status_page = 0;

    tag = "R9";
    wr(0, 0); wr(1, 1); wr(2, 64); wr(3, 128); wr(4, 255); wr(5, 200);
    wr(6, 2); wr(7, 100); wr(8, 30); wr(15, 250);
    tag = "R2";
    cyc(300);

    tag = "R4";
    for (int c = 0; c < 56; c++) wr(c, (c * 37 + 11) % 256);
    for (int b = 0; b < 7; b++) begin bank_sel = 3'(b); cyc(40); end
    tag = "R5";
    bank_sel = 3'd7; cyc(260);

    tag = "R7";
    for (int k = 0; k < 8; k++) mod_duty[k*8 +: 8] = 8'(k * 30 + 5);
    bank_sel = 3'd6; cyc(50);
    for (int c = 56; c < 64; c++) wr(c, 255);
    bank_sel = 3'd7; cyc(100);
    mod_duty = {8'd255, 8'd0, 8'd1, 8'd128, 8'd77, 8'd200, 8'd10, 8'd250};
    cyc(260);

    tag = "R3";
    bank_sel = 3'd0; status_page = 1;
    set_psc(3); cyc(600);
    set_psc(1); cyc(300);
    set_psc(255); cyc(1200);
    set_psc(0); cyc(100);
    tag = "R6";
    for (int b = 0; b < 8; b++) begin
      bank_sel = 3'(b); status_page = 1; cyc(20); status_page = 0; cyc(20);
    end

    tag = "R8";
    set_psc(2); cyc(50);
    clr = 1; wr_en = 1; wr_addr = 6'd0; wr_data = 8'd255;
    psc_we = 1; psc_data = 8'd9;
    cyc();
    clr = 0; wr_en = 0; psc_we = 0;
    mod_duty = '0;
    for (int b = 0; b < 8; b++) begin bank_sel = 3'(b); cyc(5); end
    status_page = 1; cyc(10); status_page = 0;

    tag = "R1";
    wr(9, 99); cyc(10);
    rst_n = 0; cyc(2); rst_n = 1;
    bank_sel = 3'd0; cyc(20);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired during %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule